// File: doc/BRIEF.md
# SDRAM Low-Power Entry Controller

This block decides when an SDRAM device is put to sleep after host traffic dies down, and when it is woken again. It watches two indications from the access path: a pending access request and a transfer-in-progress flag. When both have been low for long enough, and a low-power mode is selected, it drops the clock-enable pin. It may also stop the memory clock. It raises a one-cycle request toward the command generator for the matching entry command: self-refresh, power-down or deep power-down.

While the device sleeps in self-refresh or power-down, a new host request wakes it. Clock-enable and the clock come back at once. A programmable exit delay then runs, and only after it does the host get its grant. When that access and its transfer finish, the idle countdown starts again from zero and the device goes back to sleep. Deep power-down works differently: an access does not wake the device. Requests are refused with an error flag until the mode setting is changed away from deep power-down.

The idle wait is set by a 2-bit timeout selection. The choices are immediate entry, a short wait or a long wait; by default the waits are 64 and 128 cycles.

Top module: `lp_entry_ctrl`

## Requirements
- R1: During and right after synchronous reset, clock-enable and clock-gate are high, and grant, error and all three entry strobes are low.
- R2: With mode code 0 (disabled), no entry strobe is raised and clock-enable stays high, however long the block is idle.
- R3: A cycle is idle when both request and busy are low. With timeout code 0, 1, 2 or 3, the wait L is 0, SHORT_WAIT, LONG_WAIT or LONG_WAIT. Clock-enable falls together with one entry strobe at the (L+1)-th consecutive idle rising edge.
- R4: A request or busy cycle during the countdown cancels it; the full wait is counted again from the end of that transfer.
- R5: Mode code 1 (self-refresh) raises the self-refresh strobe for one cycle; in the same cycle, clock-enable and clock-gate go low.
- R6: Mode code 2 (power-down) raises the power-down strobe for one cycle; clock-enable goes low and clock-gate stays high.
- R7: A request sampled while in self-refresh or power-down raises clock-enable and clock-gate at that edge. Grant rises D+2 edges later, where D is the exit delay input; the grant is never high while clock-enable or clock-gate is low.
- R8: After a woken access and its transfer end, the block re-enters the selected low-power mode after the same R3 wait.
- R9: Mode code 3 raises the deep power-down strobe and stops the clock. Requests in that state get no grant and raise the error output one edge later. The state is left only when the mode input changes from 3, through the same exit delay as R7.
- R10: While awake and running, grant rises one edge after a request is sampled and falls one edge after it is withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Low-power mode: 0 off, 1 self-refresh, 2 power-down, 3 deep power-down |
| cfg_timeout | input | 2 | Idle wait select: 0 none, 1 short, 2 and 3 long |
| cfg_exit_dly | input | EXIT_W | Extra cycles between wake-up and grant |
| acc_req | input | 1 | Host access pending, held until granted |
| acc_busy | input | 1 | Transfer in progress on the access path |
| acc_grant | output | 1 | Access may proceed (wake-up handshake) |
| acc_err | output | 1 | Access refused while in deep power-down |
| sdram_cke | output | 1 | Memory clock-enable pin |
| sdram_clk_en | output | 1 | Memory clock gate control |
| sref_enter | output | 1 | One-cycle self-refresh entry request |
| pdn_enter | output | 1 | One-cycle power-down entry request |
| deep_enter | output | 1 | One-cycle deep power-down command request |

## Verification
The entry wait is tried with every timeout code after transfers of varied length. This separates an off-by-one count, a wait that starts at the wrong edge, and a code 3 that is decoded wrongly. A request landing in the middle of a countdown shows whether the count is restarted or only paused. Random sequences of self-refresh and power-down cycles draw a fresh exit delay and burst length each round; the measured grant latency and re-entry wait catch an exit delay that is mis-counted or a mode that is taken from the wrong cycle. Deep power-down is driven with a held request and then a mode change, which confirms both the refusal and the only way out.

// File: rtl/lp_pkg.sv
package lp_pkg;

  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_SREF = 3'd1,
    ST_PDN  = 3'd2,
    ST_DEEP = 3'd3,
    ST_WAKE = 3'd4
  } lp_state_t;

  typedef enum logic [1:0] {
    LPM_OFF  = 2'd0,
    LPM_SREF = 2'd1,
    LPM_PDN  = 2'd2,
    LPM_DEEP = 2'd3
  } lp_mode_t;

endpackage

// File: rtl/lp_idle_timer.sv
// Counts consecutive idle edges and flags when the selected wait has elapsed.
module lp_idle_timer #(
  parameter int SHORT_WAIT = 64,
  parameter int LONG_WAIT  = 128
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic [1:0] sel,
  output logic       expired
);
  localparam int CW = $clog2(LONG_WAIT + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  always_comb begin
    case (sel)
      2'd0:    limit = '0;
      2'd1:    limit = CW'(SHORT_WAIT);
      default: limit = CW'(LONG_WAIT);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (cnt != CW'(LONG_WAIT)) begin
      cnt <= cnt + 1'b1;
    end
  end

  // Comparison (not equality) so a saturated count still fires after a
  // setting change.
  assign expired = (cnt >= limit);

endmodule

// File: rtl/lp_exit_timer.sv
// Down-counter for the wake-up delay before an access is granted.
module lp_exit_timer #(
  parameter int EXIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [EXIT_W-1:0] load_val,
  output logic              done
);
  logic [EXIT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/lp_entry_ctrl.sv
module lp_entry_ctrl
  import lp_pkg::*;
#(
  parameter int SHORT_WAIT = 64,
  parameter int LONG_WAIT  = 128,
  parameter int EXIT_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_mode,
  input  logic [1:0]        cfg_timeout,
  input  logic [EXIT_W-1:0] cfg_exit_dly,
  input  logic              acc_req,
  input  logic              acc_busy,
  output logic              acc_grant,
  output logic              acc_err,
  output logic              sdram_cke,
  output logic              sdram_clk_en,
  output logic              sref_enter,
  output logic              pdn_enter,
  output logic              deep_enter
);

  lp_state_t st, st_n;
  lp_mode_t  mode;
  logic      idle_run;
  logic      wait_done;
  logic      exit_done;
  logic      go_sleep;
  logic      exit_load;

  assign mode     = lp_mode_t'(cfg_mode);
  assign idle_run = (st == ST_RUN) && !acc_req && !acc_busy;
  assign go_sleep = idle_run && wait_done && (mode != LPM_OFF);

  lp_idle_timer #(
    .SHORT_WAIT (SHORT_WAIT),
    .LONG_WAIT  (LONG_WAIT)
  ) u_idle (
    .clk     (clk),
    .rst     (rst),
    .clear   (!idle_run),
    .sel     (cfg_timeout),
    .expired (wait_done)
  );

  lp_exit_timer #(
    .EXIT_W (EXIT_W)
  ) u_exit (
    .clk      (clk),
    .rst      (rst),
    .load     (exit_load),
    .load_val (cfg_exit_dly),
    .done     (exit_done)
  );

  always_comb begin
    st_n = st;
    case (st)
      ST_RUN: begin
        if (go_sleep) begin
          case (mode)
            LPM_SREF: st_n = ST_SREF;
            LPM_PDN:  st_n = ST_PDN;
            LPM_DEEP: st_n = ST_DEEP;
            default:  st_n = ST_RUN;
          endcase
        end
      end
      ST_SREF, ST_PDN: begin
        if (acc_req) st_n = ST_WAKE;
      end
      ST_DEEP: begin
        if (mode != LPM_DEEP) st_n = ST_WAKE;
      end
      ST_WAKE: begin
        if (exit_done) st_n = ST_RUN;
      end
      default: st_n = ST_RUN;
    endcase
  end

  assign exit_load = (st_n == ST_WAKE) && (st != ST_WAKE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_RUN;
      sdram_cke    <= 1'b1;
      sdram_clk_en <= 1'b1;
      sref_enter   <= 1'b0;
      pdn_enter    <= 1'b0;
      deep_enter   <= 1'b0;
      acc_grant    <= 1'b0;
      acc_err      <= 1'b0;
    end else begin
      st           <= st_n;
      sdram_cke    <= (st_n == ST_RUN) || (st_n == ST_WAKE);
      sdram_clk_en <= (st_n != ST_SREF) && (st_n != ST_DEEP);
      sref_enter   <= (st == ST_RUN) && (st_n == ST_SREF);
      pdn_enter    <= (st == ST_RUN) && (st_n == ST_PDN);
      deep_enter   <= (st == ST_RUN) && (st_n == ST_DEEP);
      acc_grant    <= (st == ST_RUN) && acc_req;
      acc_err      <= (st == ST_DEEP) && acc_req;
    end
  end

endmodule

// File: rtl/lp_entry_ctrl_chk.sv
module lp_entry_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cfg_mode,
  input logic       acc_grant,
  input logic       acc_err,
  input logic       sdram_cke,
  input logic       sdram_clk_en,
  input logic       sref_enter,
  input logic       pdn_enter,
  input logic       deep_enter
);

  AST_OFF_NO_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'd0) |=> !(sref_enter || pdn_enter || deep_enter)); // R2

  AST_CKE_FALL_STROBE: assert property (@(posedge clk) disable iff (rst)
    $fell(sdram_cke) |-> (sref_enter || pdn_enter || deep_enter)); // R3

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sref_enter, pdn_enter, deep_enter})); // R3

  AST_SREF_CLK_STOP: assert property (@(posedge clk) disable iff (rst)
    sref_enter |-> (!sdram_cke && !sdram_clk_en)); // R5

  AST_PDN_CLK_RUN: assert property (@(posedge clk) disable iff (rst)
    pdn_enter |-> (!sdram_cke && sdram_clk_en)); // R6

  AST_GRANT_AWAKE: assert property (@(posedge clk) disable iff (rst)
    acc_grant |-> (sdram_cke && sdram_clk_en)); // R7

  AST_DEEP_CLK_STOP: assert property (@(posedge clk) disable iff (rst)
    deep_enter |-> (!sdram_cke && !sdram_clk_en)); // R9

  AST_ERR_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    acc_err |-> !acc_grant); // R9

endmodule

bind lp_entry_ctrl lp_entry_ctrl_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_mode     (cfg_mode),
  .acc_grant    (acc_grant),
  .acc_err      (acc_err),
  .sdram_cke    (sdram_cke),
  .sdram_clk_en (sdram_clk_en),
  .sref_enter   (sref_enter),
  .pdn_enter    (pdn_enter),
  .deep_enter   (deep_enter)
);

// File: tb/tb_lp_entry_ctrl.sv
`timescale 1ns/1ps
module tb_lp_entry_ctrl;

  localparam int SHORT_WAIT = 64;
  localparam int LONG_WAIT  = 128;
  localparam int EXIT_W     = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        cfg_mode = 2'd0;
  logic [1:0]        cfg_timeout = 2'd0;
  logic [EXIT_W-1:0] cfg_exit_dly = '0;
  logic              acc_req = 1'b0;
  logic              acc_busy = 1'b0;
  logic              acc_grant, acc_err, sdram_cke, sdram_clk_en;
  logic              sref_enter, pdn_enter, deep_enter;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  lp_entry_ctrl #(
    .SHORT_WAIT (SHORT_WAIT),
    .LONG_WAIT  (LONG_WAIT),
    .EXIT_W     (EXIT_W)
  ) dut (
    .clk          (clk),
    .rst          (rst),
    .cfg_mode     (cfg_mode),
    .cfg_timeout  (cfg_timeout),
    .cfg_exit_dly (cfg_exit_dly),
    .acc_req      (acc_req),
    .acc_busy     (acc_busy),
    .acc_grant    (acc_grant),
    .acc_err      (acc_err),
    .sdram_cke    (sdram_cke),
    .sdram_clk_en (sdram_clk_en),
    .sref_enter   (sref_enter),
    .pdn_enter    (pdn_enter),
    .deep_enter   (deep_enter)
  );

  function automatic int wait_of(input int code);
    if (code == 0) return 0;
    if (code == 1) return SHORT_WAIT;
    return LONG_WAIT;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string rq, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // Request, wait for grant, then hold busy for burst cycles.
  task automatic do_access(input int burst, output int lat, output int first_cke);
    acc_req = 1'b1;
    lat = 0;
    first_cke = -1;
    while (!acc_grant && lat < 60) begin
      tick();
      lat++;
      if (lat == 1) first_cke = int'(sdram_cke && sdram_clk_en);
    end
    acc_req  = 1'b0;
    acc_busy = 1'b1;
    repeat (burst) tick();
    acc_busy = 1'b0;
  endtask

  task automatic measure_entry(output int n, output int sr, output int pd,
                               output int dp, output int ck);
    n = 0;
    do begin
      tick();
      n++;
    end while (sdram_cke && n < 400);
    sr = int'(sref_enter);
    pd = int'(pdn_enter);
    dp = int'(deep_enter);
    ck = int'(sdram_clk_en);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int lat, fc, n, sr, pd, dp, ck, bad;
    void'($urandom(32'd4242));

    repeat (3) tick();
    // R1: reset state
    chk("R1 cke/clk_en", int'(sdram_cke && sdram_clk_en), 1);
    chk("R1 strobes/grant/err",
        int'(sref_enter | pdn_enter | deep_enter | acc_grant | acc_err), 0);
    rst = 1'b0;

    // R2: disabled mode never sleeps
    bad = 0;
    repeat (300) begin
      tick();
      if (!sdram_cke || sref_enter || pdn_enter || deep_enter) bad++;
    end
    chk("R2 no entry while off", bad, 0);

    // R10: grant one edge after request, drops one edge after withdrawal
    do_access(1, lat, fc);
    chk("R10 grant latency", lat, 1);
    chk("R10 grant drops", int'(acc_grant), 0);

    // R5/R3: self-refresh, short wait
    cfg_mode = 2'd1; cfg_timeout = 2'd1; cfg_exit_dly = 4'd5;
    do_access(3, lat, fc);
    measure_entry(n, sr, pd, dp, ck);
    chk("R3 short wait", n, SHORT_WAIT + 1);
    chk("R5 sref strobe", sr, 1);
    chk("R5 clock stopped", ck, 0);
    chk("R5 no pdn strobe", pd, 0);

    // R7: wake from self-refresh
    do_access(2, lat, fc);
    chk("R7 cke/clock back at once", fc, 1);
    chk("R7 grant latency", lat, 5 + 3);
    // R8: re-entry
    measure_entry(n, sr, pd, dp, ck);
    chk("R8 re-entry wait", n, SHORT_WAIT + 1);
    chk("R8 re-entry sref", sr, 1);

    // R4: cancel mid-countdown, power-down mode
    cfg_mode = 2'd2; cfg_exit_dly = 4'd0;
    do_access(2, lat, fc);
    chk("R7 zero delay latency", lat, 3);
    repeat (30) tick();
    chk("R4 still awake mid-count", int'(sdram_cke), 1);
    do_access(2, lat, fc);
    chk("R4 awake access grant", lat, 1);
    measure_entry(n, sr, pd, dp, ck);
    chk("R4 wait restarted", n, SHORT_WAIT + 1);
    chk("R6 pdn strobe", pd, 1);
    chk("R6 clock running", ck, 1);

    // R3: long wait codes and immediate
    cfg_timeout = 2'd2;
    do_access(1, lat, fc);
    measure_entry(n, sr, pd, dp, ck);
    chk("R3 long wait code 2", n, LONG_WAIT + 1);
    cfg_timeout = 2'd3;
    do_access(4, lat, fc);
    measure_entry(n, sr, pd, dp, ck);
    chk("R3 long wait code 3", n, LONG_WAIT + 1);
    cfg_timeout = 2'd0;
    do_access(2, lat, fc);
    measure_entry(n, sr, pd, dp, ck);
    chk("R3 immediate", n, 1);

    // R9: deep power-down
    cfg_mode = 2'd3;
    do_access(2, lat, fc);
    measure_entry(n, sr, pd, dp, ck);
    chk("R9 deep entry", n, 1);
    chk("R9 deep strobe", dp, 1);
    chk("R9 clock stopped", ck, 0);
    acc_req = 1'b1;
    repeat (4) tick();
    chk("R9 no grant in deep", int'(acc_grant), 0);
    chk("R9 error flag", int'(acc_err), 1);
    chk("R9 cke stays low", int'(sdram_cke), 0);
    cfg_mode = 2'd1; cfg_exit_dly = 4'd2;
    lat = 0;
    while (!acc_grant && lat < 60) begin
      tick();
      lat++;
    end
    chk("R9 exit after mode change", lat, 2 + 3);
    chk("R9 error cleared", int'(acc_err), 0);
    acc_req = 1'b0; acc_busy = 1'b1;
    tick();
    acc_busy = 1'b0;
    measure_entry(n, sr, pd, dp, ck);
    chk("R8 sleep after deep exit", sr, 1);

    // Random rounds: R3, R5, R6, R7, R8
    for (int i = 0; i < 24; i++) begin
      int m, t, d, b;
      m = 1 + int'($urandom % 2);
      t = int'($urandom % 4);
      d = int'($urandom % 16);
      b = 1 + int'($urandom % 5);
      cfg_mode = 2'(m); cfg_timeout = 2'(t); cfg_exit_dly = 4'(d);
      do_access(b, lat, fc);
      chk("R7 random wake", fc, 1);
      chk("R7 random grant latency", lat, d + 3);
      measure_entry(n, sr, pd, dp, ck);
      chk("R3 random wait", n, wait_of(t) + 1);
      chk("R5 random sref strobe", sr, int'(m == 1));
      chk("R6 random pdn strobe", pd, int'(m == 2));
      chk("R6 random clock gate", ck, int'(m == 2));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule